// File: doc/BRIEF.md
# Vectored Interrupt Arbiter with Daisy-Chained Acknowledge

This block joins four interrupt sources into a single request towards a CPU. Each source holds a status register, an 8-bit vector register and a 3-bit priority level register. A source wants service only when both its ready flag and its enable flag are set. The arbiter finds the highest level among the sources that want service. It raises `irq` with that level on `irq_pl` only when the level is strictly above the CPU's running priority, `cur_pl`. Levels run from 0, the lowest, to 7, the highest.

When the CPU answers with `cpu_iack`, the acknowledge enters the chain at source 0. Each source that is not requesting at the winning level passes it on to the next source. The first source that is requesting at the winning level absorbs it. That source places its vector on `vec` in the same cycle, with `vec_valid` high, and its ready flag clears on the next clock edge. A peripheral can set a source's ready flag through `ready_set`.

The sequencing is done by a three-state machine:
- IDLE: no request is presented. It moves to REQ when a qualifying request exists.
- REQ: `irq` is high. It moves to HOLD when `cpu_iack` is seen. It falls back to IDLE when the request stops qualifying.
- HOLD: `irq` is low and no further grant is given. It returns to IDLE once `cpu_iack` is released.

Top module: `vint_arbiter`

## Requirements
- R1: A source requests only when status bit 15 (ready) and status bit 14 (enable) are both 1. A status write sets both flags from those bits. The write is selected by `reg_sel` = 0; `reg_sel` = 1 selects the vector (bits 7:0) and `reg_sel` = 2 selects the level (bits 2:0). The target source is chosen by `reg_dev`.
- R2: `irq` rises one clock after a request whose highest level is strictly greater than `cur_pl`. A level equal to or below `cur_pl` never raises `irq`.
- R3: While `irq` is high, `irq_pl` equals the highest level among the requesting sources. While `irq` is low, `irq_pl` is 0.
- R4: Among requesters at the winning level, the one with the lowest index answers the acknowledge.
- R5: With `irq` high and `cpu_iack` high, exactly one source grants in that same cycle. `vec_valid` is then 1 and `vec` carries that source's vector. Otherwise `vec_valid` is 0 and `vec` is 0.
- R6: The granted source's ready flag clears on the next edge. `irq` is low in the following cycle, and that source no longer competes.
- R7: While `cpu_iack` stays high after a grant, no second grant occurs. The machine waits in HOLD until `cpu_iack` is low, and only then returns to IDLE.
- R8: When a source's `ready_set` bit is high in the cycle it is granted, the ready flag stays set and the source requests again.
- R9: Reset clears all registers. While reset is active and after it is released, `irq`, `irq_pl`, `vec_valid` and `vec` are 0.
- R10: If `cur_pl` rises to or above the winning level while in REQ without an acknowledge, `irq` falls on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_dev | input | 2 | Source index for the write |
| reg_sel | input | 2 | Register selector: 0 status, 1 vector, 2 level |
| reg_wdata | input | 16 | Write data |
| ready_set | input | 4 | Per-source peripheral ready event |
| cur_pl | input | 3 | Running priority of the CPU |
| cpu_iack | input | 1 | Acknowledge from the CPU |
| irq | output | 1 | Interrupt request to the CPU |
| irq_pl | output | 3 | Level of the presented request |
| vec_valid | output | 1 | A source answered the acknowledge |
| vec | output | 8 | Vector of the answering source |

## Verification
Two events can fall in the same cycle: the acknowledge clearing a source's ready flag, and a peripheral setting that same flag through `ready_set`. The bench drives `ready_set` for the winning source during the cycle in which `cpu_iack` is granted. It then releases the acknowledge and judges the outcome in two ways. The source must raise `irq` again at its own level, and a second acknowledge must return its vector. A second overlap is also exercised: a held acknowledge across several cycles of HOLD. In that case `vec_valid` must stay low until the acknowledge drops.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam int PL_W    = 3;
    localparam int VEC_W   = 8;
    localparam int STAT_W  = 16;
    localparam int RDY_BIT = 15;
    localparam int EN_BIT  = 14;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_LVL  = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_e;
endpackage

// File: rtl/vint_source.sv
module vint_source
    import vint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic             wr_vec,
    input  logic             wr_lvl,
    input  logic             wd_rdy,
    input  logic             wd_en,
    input  logic [VEC_W-1:0] wd_vec,
    input  logic [PL_W-1:0]  wd_lvl,
    input  logic             set_rdy,
    input  logic             grant,
    output logic             req,
    output logic [PL_W-1:0]  lvl,
    output logic [VEC_W-1:0] vec
);
    logic rdy_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            en_q  <= 1'b0;
            vec   <= '0;
            lvl   <= '0;
        end else begin
            if (grant)   rdy_q <= 1'b0;
            if (wr_stat) begin
                rdy_q <= wd_rdy;
                en_q  <= wd_en;
            end
            if (set_rdy) rdy_q <= 1'b1;
            if (wr_vec)  vec   <= wd_vec;
            if (wr_lvl)  lvl   <= wd_lvl;
        end
    end

    assign req = rdy_q & en_q;

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !set_rdy && !wr_stat |=> !req);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_rdy |=> rdy_q);
endmodule

// File: rtl/vint_level_max.sv
module vint_level_max
    import vint_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic [NDEV-1:0]           req,
    input  logic [NDEV-1:0][PL_W-1:0] lvl,
    output logic                      any_req,
    output logic [PL_W-1:0]           top_lvl
);
    always_comb begin
        any_req = 1'b0;
        top_lvl = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (req[i] && (lvl[i] >= top_lvl)) top_lvl = lvl[i];
            any_req = any_req | req[i];
        end
    end
endmodule

// File: rtl/vint_ack_chain.sv
module vint_ack_chain
    import vint_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic                       ack_in,
    input  logic [NDEV-1:0]            req,
    input  logic [NDEV-1:0][PL_W-1:0]  lvl,
    input  logic [PL_W-1:0]            top_lvl,
    input  logic [NDEV-1:0][VEC_W-1:0] vec_in,
    output logic [NDEV-1:0]            grant,
    output logic [VEC_W-1:0]           vec_out
);
    logic [NDEV:0] pass;
    logic          unused_tail;

    assign pass[0]     = ack_in;
    assign unused_tail = pass[NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_link
        logic hit;
        assign hit         = req[g] && (lvl[g] == top_lvl);
        assign grant[g]    = pass[g] && hit;
        assign pass[g+1]   = pass[g] && !hit;
    end

    always_comb begin
        vec_out = '0;
        for (int i = 0; i < NDEV; i++)
            vec_out = vec_out | (grant[i] ? vec_in[i] : '0);
    end
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter
    import vint_pkg::*;
#(
    parameter int NDEV  = 4,
    parameter int DEV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DEV_W-1:0]  reg_dev,
    input  logic [1:0]        reg_sel,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic [NDEV-1:0]   ready_set,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic              cpu_iack,
    output logic              irq,
    output logic [PL_W-1:0]   irq_pl,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec
);
    arb_state_e                 state, nxt;
    reg_sel_e                   sel;
    logic [NDEV-1:0]            req, grant;
    logic [NDEV-1:0][PL_W-1:0]  lvl;
    logic [NDEV-1:0][VEC_W-1:0] vecs;
    logic                       any_req, qualify, ack_go;
    logic [PL_W-1:0]            top_lvl;
    logic                       unused_wbits;

    assign sel          = reg_sel_e'(reg_sel);
    assign unused_wbits = ^reg_wdata[EN_BIT-1:VEC_W];

    for (genvar g = 0; g < NDEV; g++) begin : g_src
        logic hit_dev;
        assign hit_dev = reg_we && (reg_dev == DEV_W'(g));
        vint_source u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stat (hit_dev && sel == SEL_STAT),
            .wr_vec  (hit_dev && sel == SEL_VEC),
            .wr_lvl  (hit_dev && sel == SEL_LVL),
            .wd_rdy  (reg_wdata[RDY_BIT]),
            .wd_en   (reg_wdata[EN_BIT]),
            .wd_vec  (reg_wdata[VEC_W-1:0]),
            .wd_lvl  (reg_wdata[PL_W-1:0]),
            .set_rdy (ready_set[g]),
            .grant   (grant[g]),
            .req     (req[g]),
            .lvl     (lvl[g]),
            .vec     (vecs[g])
        );
    end

    vint_level_max #(.NDEV(NDEV)) u_max (
        .req     (req),
        .lvl     (lvl),
        .any_req (any_req),
        .top_lvl (top_lvl)
    );

    assign qualify = any_req && (top_lvl > cur_pl);

    vint_ack_chain #(.NDEV(NDEV)) u_chain (
        .ack_in  (ack_go),
        .req     (req),
        .lvl     (lvl),
        .top_lvl (top_lvl),
        .vec_in  (vecs),
        .grant   (grant),
        .vec_out (vec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (qualify) nxt = ST_REQ;
            ST_REQ: begin
                if (cpu_iack)     nxt = ST_HOLD;
                else if (!qualify) nxt = ST_IDLE;
            end
            ST_HOLD: if (!cpu_iack) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        irq       = (state == ST_REQ);
        irq_pl    = irq ? top_lvl : '0;
        ack_go    = irq && cpu_iack;
        vec_valid = |grant;
    end

    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_valid_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (cpu_iack && irq));
    p_vec_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec == '0));
    p_irq_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !irq);
    p_no_regrant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_iack && $past(cpu_iack) && $past(vec_valid)) |-> !vec_valid);
    p_pl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_pl == '0));
    p_rise_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(top_lvl > cur_pl));
endmodule

// File: tb/vint_arbiter_bench.sv
`timescale 1ns/1ps
module vint_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_dev = '0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  ready_set = '0;
    logic [2:0]  cur_pl = '0;
    logic        cpu_iack = 1'b0;
    logic        irq, vec_valid;
    logic [2:0]  irq_pl;
    logic [7:0]  vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vint_arbiter u_vint_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_dev(reg_dev),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ready_set(ready_set),
        .cur_pl(cur_pl), .cpu_iack(cpu_iack), .irq(irq), .irq_pl(irq_pl),
        .vec_valid(vec_valid), .vec(vec)
    );

    typedef struct packed {
        logic [3:0]      rdy;
        logic [3:0]      en;
        logic [3:0][2:0] lvl;
        logic [2:0]      cpl;
        logic            exp_irq;
        logic [2:0]      exp_pl;
        logic [1:0]      exp_dev;
    } row_t;

    localparam int NROW = 10;
    localparam row_t TBL [NROW] = '{
        '{4'b0100, 4'b0100, {3'd0,3'd5,3'd0,3'd0}, 3'd2, 1'b1, 3'd5, 2'd2},
        '{4'b1010, 4'b1000, {3'd3,3'd0,3'd6,3'd0}, 3'd0, 1'b1, 3'd3, 2'd3},
        '{4'b0001, 4'b0001, {3'd0,3'd0,3'd0,3'd4}, 3'd4, 1'b0, 3'd0, 2'd0},
        '{4'b0101, 4'b0101, {3'd0,3'd6,3'd0,3'd4}, 3'd5, 1'b1, 3'd6, 2'd2},
        '{4'b1010, 4'b1010, {3'd3,3'd0,3'd3,3'd0}, 3'd1, 1'b1, 3'd3, 2'd1},
        '{4'b1000, 4'b1001, {3'd1,3'd0,3'd0,3'd7}, 3'd0, 1'b1, 3'd1, 2'd3},
        '{4'b0000, 4'b1111, {3'd7,3'd7,3'd7,3'd7}, 3'd0, 1'b0, 3'd0, 2'd0},
        '{4'b1111, 4'b1111, {3'd2,3'd2,3'd2,3'd2}, 3'd7, 1'b0, 3'd0, 2'd0},
        '{4'b1111, 4'b1111, {3'd2,3'd2,3'd2,3'd2}, 3'd1, 1'b1, 3'd2, 2'd0},
        '{4'b0111, 4'b0111, {3'd0,3'd7,3'd7,3'd1}, 3'd6, 1'b1, 3'd7, 2'd1}
    };

    function automatic logic [7:0] dev_vec(input int d);
        return 8'h30 + 8'(d * 17);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int d, input logic [1:0] sel, input logic [15:0] data);
        reg_we = 1'b1; reg_dev = d[1:0]; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check("R9", "irq in reset", irq, 0);
        check("R9", "irq_pl in reset", irq_pl, 0);
        check("R9", "vec_valid in reset", vec_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "irq after reset", irq, 0);
        check("R9", "vec after reset", vec, 0);

        for (int d = 0; d < 4; d++) wr(d, 2'd1, {8'h00, dev_vec(d)});

        // table walk: R1 R2 R3 R4 R5 R6
        for (int r = 0; r < NROW; r++) begin
            cur_pl = TBL[r].cpl;
            for (int d = 0; d < 4; d++) begin
                wr(d, 2'd2, {13'd0, TBL[r].lvl[d]});
                wr(d, 2'd0, {TBL[r].rdy[d], TBL[r].en[d], 14'd0});
            end
            @(negedge clk);
            check("R2", $sformatf("row %0d irq", r), irq, TBL[r].exp_irq);
            check("R3", $sformatf("row %0d irq_pl", r), irq_pl, TBL[r].exp_pl);
            check("R5", $sformatf("row %0d vec idle", r), vec, 0);
            if (TBL[r].exp_irq) begin
                cpu_iack = 1'b1;
                #1;
                check("R5", $sformatf("row %0d vec_valid", r), vec_valid, 1);
                check("R4", $sformatf("row %0d vec", r), vec, dev_vec(TBL[r].exp_dev));
                @(negedge clk);
                check("R6", $sformatf("row %0d irq after ack", r), irq, 0);
                cpu_iack = 1'b0;
                @(negedge clk);
            end
        end

        // clear all status
        for (int d = 0; d < 4; d++) wr(d, 2'd0, 16'h0000);
        cur_pl = 3'd0;

        // R6 / R7: held acknowledge, then the next source
        wr(0, 2'd2, 16'd5);
        wr(1, 2'd2, 16'd3);
        wr(0, 2'd0, 16'hC000);
        wr(1, 2'd0, 16'hC000);
        @(negedge clk);
        check("R3", "two levels irq_pl", irq_pl, 5);
        cpu_iack = 1'b1;
        #1;
        check("R5", "first grant vec", vec, dev_vec(0));
        @(negedge clk);
        check("R7", "hold irq", irq, 0);
        check("R7", "hold vec_valid", vec_valid, 0);
        @(negedge clk);
        check("R7", "still held vec_valid", vec_valid, 0);
        cpu_iack = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", "next irq", irq, 1);
        check("R6", "next irq_pl", irq_pl, 3);
        cpu_iack = 1'b1;
        #1;
        check("R6", "second grant vec", vec, dev_vec(1));
        @(negedge clk);
        cpu_iack = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", "all served irq", irq, 0);

        // R8: ready_set during the grant cycle
        wr(2, 2'd2, 16'd4);
        wr(2, 2'd0, 16'hC000);
        @(negedge clk);
        check("R8", "irq before", irq, 1);
        cpu_iack = 1'b1;
        ready_set = 4'b0100;
        #1;
        check("R8", "grant vec", vec, dev_vec(2));
        @(negedge clk);
        ready_set = 4'b0000;
        cpu_iack = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "request survives irq", irq, 1);
        check("R8", "request survives irq_pl", irq_pl, 4);
        cpu_iack = 1'b1;
        #1;
        check("R8", "regrant vec", vec, dev_vec(2));
        @(negedge clk);
        cpu_iack = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", "served irq", irq, 0);

        // R10: running priority rises while pending
        wr(3, 2'd2, 16'd3);
        wr(3, 2'd0, 16'hC000);
        @(negedge clk);
        check("R10", "pending irq", irq, 1);
        cur_pl = 3'd3;
        @(negedge clk);
        check("R10", "irq withdrawn", irq, 0);
        check("R3", "irq_pl withdrawn", irq_pl, 0);
        cur_pl = 3'd2;
        @(negedge clk);
        check("R2", "irq returns", irq, 1);

        // R1: enable cleared, ready kept
        wr(3, 2'd0, 16'h8000);
        @(negedge clk);
        check("R1", "ready without enable", irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule